// File: doc/BRIEF.md
# Watchdog Timer with Partial Prescaler Clear

This block is a watchdog that forces a reset when software stops servicing it. A free-running prescaler divides the input clock. Each time its top stage goes from 0 to 1, a one-cycle tap is produced, and that tap advances an 8-bit timeout counter. When the timeout counter passes its terminal value, the block issues a one-cycle reset request and a one-cycle pulse that sets the watchdog flag in the status register.

Software services the watchdog by writing to the all-ones address. The data value does not matter. A service clears the timeout counter and the upper prescaler stages. The low prescaler stages keep counting, so the time from a service to the next tap is bounded but not exact. The watchdog can be turned off only by a combinational function of the high-voltage pin conditions, qualified by monitor mode or by a break state. No register bit can disable it.

Top module: `wdog_timer`

## Requirements
- R1: While `porRstN` is low, `wdogRstReq` and `wdogFlagSet` are low, and the prescaler, the tap history and the timeout counter are all zero. After release, the first request comes exactly 2^WDOG_W taps later.
- R2: The prescaler adds one on every clock. A tap is a cycle in which the prescaler's top stage reads 1 and read 0 in the cycle before. With no service and no disable, requests repeat every 2^PRE_STAGES × 2^WDOG_W cycles exactly.
- R3: A service is a cycle in which `busWrStb` is high and `busAddr` equals the service address (0xFFFF by default). A strobe to any other address has no effect on the timeout.
- R4: On a service, the timeout counter and prescaler stages KEEP_STAGES and above become zero. Stages below KEEP_STAGES keep counting. Periodic service faster than the timeout prevents every request.
- R5: A tap that finds the timeout counter at its maximum while the watchdog is enabled wraps the counter to zero. In the next cycle it raises `wdogRstReq` and `wdogFlagSet` together for exactly one cycle.
- R6: A service in the same cycle as an overflowing tap wins: no request is raised and the counter restarts from zero.
- R7: With `monMode` high and either `hvOnRst` or `hvOnIrq` high, the timeout counter holds and no request is raised.
- R8: With `brkState` high, `hvOnRst` disables the watchdog. `hvOnIrq` alone does not.
- R9: The high-voltage inputs have no effect without monitor mode or a break state. Counting resumes in the first cycle after the disabling pin condition goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| busWrStb | input | 1 | Bus write strobe |
| busAddr | input | ADDR_W | Bus write address |
| monMode | input | 1 | Chip is in monitor mode |
| hvOnRst | input | 1 | High-voltage level detected on the reset pin |
| hvOnIrq | input | 1 | High-voltage level detected on the interrupt pin |
| brkState | input | 1 | Chip is in a break state |
| wdogRstReq | output | 1 | One-cycle watchdog reset request |
| wdogFlagSet | output | 1 | One-cycle pulse that sets the watchdog status flag |

## Verification
The hardest case to reach from the ports is a service write that lands in the exact cycle of an overflowing tap. That cycle occurs only once per full timeout period, and its position depends on the unseen prescaler phase.

The bench keeps its own cycle model of the prescaler and the timeout counter. It watches that model until the next edge would be the overflowing tap, and it drives the service write for exactly that edge.

Free-running runs measure the exact request interval. Sweeps over pin combinations cover each disable term and each non-disabling term.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic preClrHi;  // clear upper prescaler stages
    logic cntClr;    // clear timeout counter
    logic cntInc;    // advance timeout counter
    logic ovfFire;   // timeout counter passes terminal value
  } wdogStrobes_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = {ADDR_W{1'b1}}
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              busWrStb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              monMode,
  input  logic              hvOnRst,
  input  logic              hvOnIrq,
  input  logic              brkState,
  input  logic              preTop,
  input  logic              cntAtMax,
  output wdogStrobes_t      strobes
);
  logic topPrev;
  logic tap;
  logic svcHit;
  logic wdogOff;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) topPrev <= 1'b0;
    else          topPrev <= preTop;
  end

  assign tap    = preTop & ~topPrev;
  assign svcHit = busWrStb && (busAddr == SVC_ADDR);

  // Pin-driven disable; intentionally no stored term
  assign wdogOff = (monMode & (hvOnRst | hvOnIrq)) | (brkState & hvOnRst);

  always_comb begin
    strobes          = '0;
    strobes.preClrHi = svcHit;
    strobes.cntClr   = svcHit;
    strobes.cntInc   = tap & ~wdogOff & ~svcHit;
    strobes.ovfFire  = tap & ~wdogOff & ~svcHit & cntAtMax;
  end
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int PRE_STAGES  = 12,
  parameter int KEEP_STAGES = 4,
  parameter int WDOG_W      = 8
) (
  input  logic         clk,
  input  logic         porRstN,
  input  wdogStrobes_t strobes,
  output logic         preTop,
  output logic         cntAtMax,
  output logic         wdogRstReq,
  output logic         wdogFlagSet
);
  localparam int CLR_STAGES = PRE_STAGES - KEEP_STAGES;

  logic [PRE_STAGES-1:0] preCnt;
  logic [PRE_STAGES-1:0] preBase;
  logic [WDOG_W-1:0]     wdogCnt;
  logic                  reqQ;
  logic                  flagQ;

  // Base value the prescaler counts up from this cycle
  generate
    if (KEEP_STAGES == 0) begin : g_clrAll
      assign preBase = strobes.preClrHi ? '0 : preCnt;
    end else begin : g_clrUpper
      assign preBase = strobes.preClrHi
                     ? {{CLR_STAGES{1'b0}}, preCnt[KEEP_STAGES-1:0]}
                     : preCnt;
    end
  endgenerate

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) preCnt <= '0;
    else          preCnt <= preBase + 1'b1;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)            wdogCnt <= '0;
    else if (strobes.cntClr) wdogCnt <= '0;
    else if (strobes.cntInc) wdogCnt <= wdogCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      reqQ  <= 1'b0;
      flagQ <= 1'b0;
    end else begin
      reqQ  <= strobes.ovfFire;
      flagQ <= strobes.ovfFire;
    end
  end

  assign preTop      = preCnt[PRE_STAGES-1];
  assign cntAtMax    = &wdogCnt;
  assign wdogRstReq  = reqQ;
  assign wdogFlagSet = flagQ;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int PRE_STAGES  = 12,
  parameter int KEEP_STAGES = 4,
  parameter int WDOG_W      = 8,
  parameter int ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = {ADDR_W{1'b1}}
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              busWrStb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              monMode,
  input  logic              hvOnRst,
  input  logic              hvOnIrq,
  input  logic              brkState,
  output logic              wdogRstReq,
  output logic              wdogFlagSet
);
  wdogStrobes_t strobes;
  logic         preTop;
  logic         cntAtMax;

  wdog_ctrl #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) u_ctrl (
    .clk      (clk),
    .porRstN  (porRstN),
    .busWrStb (busWrStb),
    .busAddr  (busAddr),
    .monMode  (monMode),
    .hvOnRst  (hvOnRst),
    .hvOnIrq  (hvOnIrq),
    .brkState (brkState),
    .preTop   (preTop),
    .cntAtMax (cntAtMax),
    .strobes  (strobes)
  );

  wdog_datapath #(
    .PRE_STAGES (PRE_STAGES),
    .KEEP_STAGES(KEEP_STAGES),
    .WDOG_W     (WDOG_W)
  ) u_dp (
    .clk        (clk),
    .porRstN    (porRstN),
    .strobes    (strobes),
    .preTop     (preTop),
    .cntAtMax   (cntAtMax),
    .wdogRstReq (wdogRstReq),
    .wdogFlagSet(wdogFlagSet)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = {ADDR_W{1'b1}}
) (
  input logic              clk,
  input logic              porRstN,
  input logic              busWrStb,
  input logic [ADDR_W-1:0] busAddr,
  input logic              monMode,
  input logic              hvOnRst,
  input logic              hvOnIrq,
  input logic              brkState,
  input logic              wdogRstReq,
  input logic              wdogFlagSet
);
  logic offSeen;
  logic svcSeen;
  assign offSeen = (monMode & (hvOnRst | hvOnIrq)) | (brkState & hvOnRst);
  assign svcSeen = busWrStb && (busAddr == SVC_ADDR);

  // R1: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!porRstN) begin
      a_r1_reset_quiet: assert (!wdogRstReq && !wdogFlagSet);
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!porRstN)
    wdogRstReq |=> !wdogRstReq);

  a_r5_flag_with_req: assert property (@(posedge clk) disable iff (!porRstN)
    wdogRstReq == wdogFlagSet);

  a_r6_service_wins: assert property (@(posedge clk) disable iff (!porRstN)
    svcSeen |=> !wdogRstReq);

  a_r7_disabled_no_req: assert property (@(posedge clk) disable iff (!porRstN)
    offSeen |=> !wdogRstReq);
endmodule

bind wdog_timer wdog_checker #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) u_wdogChk (
  .clk        (clk),
  .porRstN    (porRstN),
  .busWrStb   (busWrStb),
  .busAddr    (busAddr),
  .monMode    (monMode),
  .hvOnRst    (hvOnRst),
  .hvOnIrq    (hvOnIrq),
  .brkState   (brkState),
  .wdogRstReq (wdogRstReq),
  .wdogFlagSet(wdogFlagSet)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  localparam int PRE  = 6;
  localparam int KEEP = 2;
  localparam int WW   = 3;
  localparam int PRE_MOD = 1 << PRE;
  localparam int TOPV    = 1 << (PRE - 1);
  localparam int LOWM    = (1 << KEEP) - 1;
  localparam int WMAX    = (1 << WW) - 1;
  localparam int PERIOD  = PRE_MOD * (WMAX + 1);

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        busWrStb = 1'b0;
  logic [15:0] busAddr = 16'h0000;
  logic        monMode = 1'b0;
  logic        hvOnRst = 1'b0;
  logic        hvOnIrq = 1'b0;
  logic        brkState = 1'b0;
  logic        wdogRstReq;
  logic        wdogFlagSet;

  always #2.5 clk = ~clk;

  wdog_timer #(.PRE_STAGES(PRE), .KEEP_STAGES(KEEP), .WDOG_W(WW)) u_wdog_timer (
    .clk(clk), .porRstN(porRstN), .busWrStb(busWrStb), .busAddr(busAddr),
    .monMode(monMode), .hvOnRst(hvOnRst), .hvOnIrq(hvOnIrq), .brkState(brkState),
    .wdogRstReq(wdogRstReq), .wdogFlagSet(wdogFlagSet)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  string curTag  = "R1";
  bit    expQ[$];
  int    mPre = 0, mPrevTop = 0, mWd = 0;
  int    cycleNo = 0, lastPulse = -1, lastGap = -1, pulseCnt = 0;
  bit    finished = 1'b0;

  task automatic check(string tag, bit ok, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver-side reference: pushes the expected output for the cycle after each edge
  always @(posedge clk) begin
    bit svc, dis, tap, ovf;
    if (!porRstN) begin
      mPre = 0; mPrevTop = 0; mWd = 0;
      expQ.push_back(1'b0);
    end else begin
      svc = busWrStb && (busAddr == 16'hFFFF);
      dis = (monMode && (hvOnRst || hvOnIrq)) || (brkState && hvOnRst);
      tap = ((mPre & TOPV) != 0) && (mPrevTop == 0);
      ovf = tap && (mWd == WMAX) && !dis && !svc;
      expQ.push_back(ovf);
      mPrevTop = ((mPre & TOPV) != 0) ? 1 : 0;
      mPre = ((svc ? (mPre & LOWM) : mPre) + 1) % PRE_MOD;
      if (svc) mWd = 0;
      else if (tap && !dis) mWd = (mWd + 1) % (WMAX + 1);
    end
  end

  // Monitor: compares outputs against the queue away from the active edge
  always @(negedge clk) begin
    bit e;
    cycleNo++;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      check(curTag, wdogRstReq == e, int'(wdogRstReq), int'(e));
      check(curTag, wdogFlagSet == e, int'(wdogFlagSet), int'(e));
      if (wdogRstReq) begin
        pulseCnt++;
        if (lastPulse >= 0) lastGap = cycleNo - lastPulse;
        lastPulse = cycleNo;
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startPhase(string tag);
    @(negedge clk);
    curTag = tag;
    pulseCnt = 0;
  endtask

  task automatic writeAt(logic [15:0] a);
    @(negedge clk);
    busWrStb = 1'b1; busAddr = a;
    @(negedge clk);
    busWrStb = 1'b0; busAddr = 16'h0000;
  endtask

  task automatic expectPulses(string tag, int lo, int hi);
    check(tag, pulseCnt >= lo && pulseCnt <= hi, pulseCnt, lo);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    idle(4);
    check("R1", !wdogRstReq && !wdogFlagSet, int'(wdogRstReq), 0);
    porRstN = 1'b1;

    // R1/R2: free run, exact request spacing
    curTag = "R2";
    idle(1200);
    expectPulses("R2", 2, 2);
    check("R2", lastGap == PERIOD, lastGap, PERIOD);

    // R3: strobes to a neighbouring address do not service
    startPhase("R3");
    repeat (11) begin writeAt(16'hFFFE); idle(98); end
    expectPulses("R3", 2, 3);

    // R4: periodic real service holds off every request
    startPhase("R4");
    repeat (7) begin writeAt(16'hFFFF); idle(290); end
    expectPulses("R4", 0, 0);

    // R5: free-running again after service, one-cycle pulses
    startPhase("R5");
    idle(1100);
    expectPulses("R5", 2, 3);
    check("R5", lastGap == PERIOD, lastGap, PERIOD);

    // R6: service aimed at the overflowing tap
    startPhase("R6");
    forever begin
      @(negedge clk);
      if (((mPre & TOPV) != 0) && mPrevTop == 0 && mWd == WMAX) break;
    end
    busWrStb = 1'b1; busAddr = 16'hFFFF;
    @(negedge clk);
    busWrStb = 1'b0; busAddr = 16'h0000;
    idle(20);
    expectPulses("R6", 0, 0);

    // R7: monitor mode with either high-voltage pin
    startPhase("R7");
    monMode = 1'b1; hvOnIrq = 1'b1;
    idle(1500);
    hvOnIrq = 1'b0; hvOnRst = 1'b1;
    idle(1500);
    expectPulses("R7", 0, 0);
    monMode = 1'b0; hvOnRst = 1'b0;

    // R8: break state, interrupt pin alone does not disable
    startPhase("R8");
    brkState = 1'b1; hvOnIrq = 1'b1;
    idle(1200);
    expectPulses("R8", 2, 3);
    startPhase("R8");
    hvOnIrq = 1'b0; hvOnRst = 1'b1;
    idle(1200);
    expectPulses("R8", 0, 0);
    brkState = 1'b0;

    // R9: high voltage alone does nothing; counting resumes
    startPhase("R9");
    hvOnIrq = 1'b1;
    idle(1200);
    expectPulses("R9", 2, 3);
    hvOnRst = 1'b0; hvOnIrq = 1'b0;
    idle(4);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule